// File: doc/BRIEF.md
# Potentiometer Wiper Register Bank

This block is the register back end that sits behind a serial-bus slave engine in a digitally controlled potentiometer. The engine decodes the bus framing and hands over START and STOP events, each received byte (flagged as either the register pointer byte or a data byte) and read requests. The block answers every byte with an acknowledge decision, returns read data, and drives the 8-bit tap select for the resistor ladder.

The bank has a volatile wiper register, a stored initial wiper value, five stored general-purpose bytes, a fixed identity byte and a one-bit access-control field. The stored bytes are flip-flops that are cleared only by a separate storage reset, so they survive the ordinary reset. A stored write is held pending and is committed only if the next event after the acknowledge is STOP. The block then reports busy for a programmable number of clocks. After reset, the wiper starts at midscale and loads the stored initial value on the first clock.

Bytes enter through a valid/ready channel. `in_ready` is low during the boot cycle and during a busy period, and the engine must keep `in_valid`, `in_addr` and `in_data` stable until a cycle in which both valid and ready are high. The `ack_valid`/`ack` and `rd_valid`/`rd_data` responses are single-cycle pulses that the engine always takes. `rd_req` is ignored while busy or before boot completes.

Top module: `rvb_wiper_bank`

## Requirements
- R1: While `rst_n` is low, `tap_sel` is 80h and `boot_done` is 0. At the first clock edge after release, `tap_sel` takes the stored initial value and `boot_done` rises. The storage reset sets the initial value to 80h and all general-purpose bytes to 00h.
- R2: A pointer byte (`in_addr`=1) with value 00h–06h or 08h is acknowledged (`ack`=1). The value 07h or any value above 08h gets `ack`=0, and every following data byte in the same transfer is also answered with `ack`=0 and changes nothing.
- R3: Register 08h holds the mode bit in bit 7 and reads back as {mode,0000000}. Writing 00h or 80h is acknowledged. Any other value still loads bit 7 but gets `ack`=0.
- R4: Register 00h is banked by the mode bit. With mode=0, a write updates both the wiper and the stored initial value, and a read returns the stored value. With mode=1, a write updates only the wiper and does not start a storage cycle, and a read returns the wiper.
- R5: Register 01h always reads D0h. A write to it is acknowledged and changes nothing.
- R6: Registers 02h–06h are stored bytes that read back the last committed value.
- R7: Each read returns the register at the pointer and then advances the pointer, with 08h followed by 00h. A sequential read that reaches 07h returns FFh there.
- R8: A stored write is committed only when STOP is the next event after its data byte. A START, another byte or a read request in between discards it.
- R9: A wiper write (register 00h, either mode) shows on `tap_sel` in the cycle after the byte is accepted, without waiting for STOP. `tap_sel` changes at no other time after boot.
- R10: A second data byte in one transfer is allowed only when the pointer byte was 08h. After any stored-register data byte, later data bytes get `ack`=0 and discard the pending write.
- R11: While `wp_n` is low, a data byte aimed at a stored register gets `ack`=0 and changes nothing, the wiper included. If `wp_n` is low at STOP, the pending write is dropped. `wp_n` going low after a commit has started has no effect.
- R12: A commit raises `busy` in the cycle after STOP, and `busy` stays high for exactly NV_CYCLES clocks. During that time `in_ready` is low and `rd_req` produces no `rd_valid`.
- R13: `ack_valid` pulses exactly in the cycle after a byte is accepted, and `rd_valid` pulses in the cycle after an accepted `rd_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of volatile state |
| nv_rst_n | input | 1 | Active-low reset of the stored bytes to their default values |
| wp_n | input | 1 | Write protect, active low |
| bus_start | input | 1 | One-cycle pulse on START or repeated START |
| bus_stop | input | 1 | One-cycle pulse on STOP |
| in_valid | input | 1 | A received byte is offered |
| in_ready | output | 1 | The block can take a byte |
| in_addr | input | 1 | 1 = pointer byte, 0 = data byte |
| in_data | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision is valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| rd_req | input | 1 | One-cycle request for the next read byte |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Storage write cycle in progress |
| tap_sel | output | 8 | Wiper tap select |
| boot_done | output | 1 | Initial wiper load has completed |

## Verification
The hardest states to reach from the ports are those where a stored write is pending and something other than STOP arrives next: a repeated START, a further byte in a transfer that began at 08h, or `wp_n` falling just before STOP. Directed sequences place each of these interruptions right after the stored data byte. Random transfers then mix the ending (STOP or START), the write-protect level, the byte count and the pointer, including the illegal pointers. A second reset that leaves the stored bytes intact checks that the wiper reloads a committed initial value.

// File: rtl/rvb_pkg.sv
package rvb_pkg;
  parameter int unsigned DW = 8;
  parameter int unsigned AW = 4;
  parameter logic [AW-1:0] A_BANK  = 4'd0;
  parameter logic [AW-1:0] A_ID    = 4'd1;
  parameter logic [AW-1:0] A_GP_LO = 4'd2;
  parameter logic [AW-1:0] A_GP_HI = 4'd6;
  parameter logic [AW-1:0] A_RSV   = 4'd7;
  parameter logic [AW-1:0] A_CTRL  = 4'd8;
  parameter int unsigned GP_NUM = int'(A_GP_HI) - int'(A_GP_LO) + 1;
  parameter logic [DW-1:0] WIPER_MID = 8'h80;
  parameter logic [DW-1:0] RSV_VAL   = 8'hFF;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == A_CTRL) ? A_BANK : p + 1'b1;
  endfunction
endpackage

// File: rtl/rvb_nv_store.sv
module rvb_nv_store
  import rvb_pkg::*;
#(
  parameter int unsigned NV_CYCLES = 200,
  parameter logic [DW-1:0] IVR_DEFAULT = 8'h80
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       nv_rst_n,
  input  logic                       commit,
  input  logic [AW-1:0]              commit_addr,
  input  logic [DW-1:0]              commit_data,
  output logic [DW-1:0]              ivr,
  output logic [GP_NUM-1:0][DW-1:0]  gp,
  output logic                       busy
);
  localparam int unsigned TW = $clog2(NV_CYCLES + 1);
  logic [TW-1:0] cyc_cnt;

  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n) ivr <= IVR_DEFAULT;
    else if (commit && commit_addr == A_BANK) ivr <= commit_data;
  end

  for (genvar g = 0; g < GP_NUM; g++) begin : g_gp
    always_ff @(posedge clk or negedge nv_rst_n) begin
      if (!nv_rst_n) gp[g] <= '0;
      else if (commit && commit_addr == AW'(int'(A_GP_LO) + g)) gp[g] <= commit_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_cnt <= '0;
    else if (commit) cyc_cnt <= TW'(NV_CYCLES);
    else if (cyc_cnt != '0) cyc_cnt <= cyc_cnt - 1'b1;
  end

  assign busy = (cyc_cnt != '0);
endmodule

// File: rtl/rvb_ctl.sv
module rvb_ctl
  import rvb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          byte_go,
  input  logic          byte_is_addr,
  input  logic [DW-1:0] byte_data,
  input  logic          rd_go,
  input  logic [DW-1:0] rd_value,
  output logic          vol,
  output logic [AW-1:0] ptr,
  output logic          ack_valid,
  output logic          ack,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          wr_we,
  output logic [DW-1:0] wr_data,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data
);
  logic addr_ok, from_ctrl, seen_data, locked, pend;
  logic nv_tgt, seq_ok, addr_ack, data_ack;

  always_comb begin
    nv_tgt   = (ptr == A_BANK && !vol) || (ptr >= A_GP_LO && ptr <= A_GP_HI);
    seq_ok   = addr_ok && !locked && (!seen_data || from_ctrl);
    addr_ack = (byte_data <= 8'(A_CTRL)) && (byte_data != 8'(A_RSV));
    data_ack = 1'b0;
    if (seq_ok) begin
      if (ptr == A_CTRL)                data_ack = (byte_data[DW-2:0] == '0);
      else if (ptr == A_ID)             data_ack = 1'b1;
      else if (ptr == A_BANK && vol)    data_ack = 1'b1;
      else if (nv_tgt)                  data_ack = wp_n;
    end
    wr_we   = byte_go && !byte_is_addr && seq_ok && ptr == A_BANK && (vol || wp_n);
    wr_data = byte_data;
    commit  = bus_stop && pend && wp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol <= 1'b0; ptr <= A_BANK; addr_ok <= 1'b0; from_ctrl <= 1'b0;
      seen_data <= 1'b0; locked <= 1'b0; pend <= 1'b0;
      commit_addr <= '0; commit_data <= '0;
      ack_valid <= 1'b0; ack <= 1'b0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      ack_valid <= byte_go;
      rd_valid  <= rd_go;
      if (byte_go) ack <= byte_is_addr ? addr_ack : data_ack;
      if (rd_go) rd_data <= rd_value;
      if (bus_start || bus_stop) begin
        addr_ok <= 1'b0; pend <= 1'b0; locked <= 1'b0;
      end else if (byte_go) begin
        pend <= 1'b0;
        if (byte_is_addr) begin
          addr_ok <= addr_ack;
          if (addr_ack) begin
            ptr <= byte_data[AW-1:0];
            from_ctrl <= (byte_data[AW-1:0] == A_CTRL);
            seen_data <= 1'b0;
            locked <= 1'b0;
          end
        end else if (seq_ok) begin
          seen_data <= 1'b1;
          ptr <= ptr_next(ptr);
          if (ptr == A_CTRL) vol <= byte_data[DW-1];
          if (nv_tgt) begin
            locked <= 1'b1;
            if (wp_n) begin
              pend <= 1'b1; commit_addr <= ptr; commit_data <= byte_data;
            end
          end
        end else begin
          locked <= 1'b1;
        end
      end else if (rd_go) begin
        pend <= 1'b0;
        ptr <= ptr_next(ptr);
      end
    end
  end
endmodule

// File: rtl/rvb_wiper.sv
module rvb_wiper
  import rvb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ivr,
  input  logic          wr_we,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] wiper,
  output logic          booted
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper <= WIPER_MID; booted <= 1'b0;
    end else if (!booted) begin
      wiper <= ivr; booted <= 1'b1;
    end else if (wr_we) begin
      wiper <= wr_data;
    end
  end
endmodule

// File: rtl/rvb_wiper_bank.sv
module rvb_wiper_bank
  import rvb_pkg::*;
#(
  parameter int unsigned NV_CYCLES = 200,
  parameter logic [DW-1:0] ID_VALUE = 8'hD0,
  parameter logic [DW-1:0] IVR_DEFAULT = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nv_rst_n,
  input  logic          wp_n,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_addr,
  input  logic [DW-1:0] in_data,
  output logic          ack_valid,
  output logic          ack,
  input  logic          rd_req,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic [DW-1:0] tap_sel,
  output logic          boot_done
);
  logic                      vol, wr_we, commit, byte_go, rd_go;
  logic [AW-1:0]             ptr, commit_addr;
  logic [DW-1:0]             wr_data, commit_data, ivr, rd_value;
  logic [GP_NUM-1:0][DW-1:0] gp;

  assign in_ready = boot_done && !busy;
  assign byte_go  = in_valid && in_ready;
  assign rd_go    = rd_req && in_ready;

  always_comb begin
    if (ptr == A_BANK)                          rd_value = vol ? tap_sel : ivr;
    else if (ptr == A_ID)                       rd_value = ID_VALUE;
    else if (ptr >= A_GP_LO && ptr <= A_GP_HI)  rd_value = gp[ptr - A_GP_LO];
    else if (ptr == A_CTRL)                     rd_value = {vol, {(DW-1){1'b0}}};
    else                                        rd_value = RSV_VAL;
  end

  rvb_ctl i_ctl (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_go(byte_go), .byte_is_addr(in_addr), .byte_data(in_data),
    .rd_go(rd_go), .rd_value(rd_value), .vol(vol), .ptr(ptr),
    .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_we(wr_we), .wr_data(wr_data), .commit(commit),
    .commit_addr(commit_addr), .commit_data(commit_data)
  );

  rvb_nv_store #(.NV_CYCLES(NV_CYCLES), .IVR_DEFAULT(IVR_DEFAULT)) i_nv (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .commit(commit),
    .commit_addr(commit_addr), .commit_data(commit_data),
    .ivr(ivr), .gp(gp), .busy(busy)
  );

  rvb_wiper i_wiper (
    .clk(clk), .rst_n(rst_n), .ivr(ivr), .wr_we(wr_we), .wr_data(wr_data),
    .wiper(tap_sel), .booted(boot_done)
  );
endmodule

// File: rtl/rvb_chk.sv
module rvb_chk
  import rvb_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_stop,
  input logic          in_valid,
  input logic          in_ready,
  input logic          ack_valid,
  input logic          rd_req,
  input logic          rd_valid,
  input logic          busy,
  input logic [DW-1:0] tap_sel,
  input logic          boot_done
);
  // R1
  boot_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> tap_sel == WIPER_MID);
  // R9
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done && !(in_valid && in_ready) |=> $stable(tap_sel));
  // R8
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));
  // R12
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  // R13
  ack_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ack_valid);
  // R13
  rd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && in_ready |=> rd_valid);
  // R12
  rd_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && busy |=> !rd_valid);
endmodule

bind rvb_wiper_bank rvb_chk i_rvb_chk (
  .clk(clk), .rst_n(rst_n), .bus_stop(bus_stop), .in_valid(in_valid),
  .in_ready(in_ready), .ack_valid(ack_valid), .rd_req(rd_req), .rd_valid(rd_valid),
  .busy(busy), .tap_sel(tap_sel), .boot_done(boot_done)
);

// File: tb/test_rvb_wiper_bank.sv
module test_rvb_wiper_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NVC = 12;

  logic clk = 1'b0, rst_n = 1'b0, nv_rst_n = 1'b0, wp_n = 1'b1;
  logic bus_start = 1'b0, bus_stop = 1'b0, in_valid = 1'b0, in_addr = 1'b0, rd_req = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, ack_valid, ack, rd_valid, busy, boot_done;
  logic [7:0] rd_data, tap_sel;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit [7:0] m_nv [0:8];
  bit [7:0] m_wr;
  bit [3:0] m_ptr;
  bit m_vol, m_aok, m_s08, m_seen, m_lock, m_pend;
  bit [3:0] m_pa;
  bit [7:0] m_pd;

  always #(CLK_PERIOD/2) clk = ~clk;

  rvb_wiper_bank #(.NV_CYCLES(NVC)) i_rvb_wiper_bank (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .wp_n(wp_n),
    .bus_start(bus_start), .bus_stop(bus_stop), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .ack_valid(ack_valid), .ack(ack),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .tap_sel(tap_sel), .boot_done(boot_done)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic bit [3:0] nxt(input bit [3:0] p);
    return (p == 4'd8) ? 4'd0 : p + 4'd1;
  endfunction

  function automatic bit [7:0] exp_rd(input bit [3:0] p);
    if (p == 0) return m_vol ? m_wr : m_nv[0];
    if (p == 1) return 8'hD0;
    if (p >= 2 && p <= 6) return m_nv[p];
    if (p == 8) return {m_vol, 7'd0};
    return 8'hFF;
  endfunction

  task automatic model_reset(input bit nv_too);
    if (nv_too) begin
      foreach (m_nv[i]) m_nv[i] = 8'h00;
      m_nv[0] = 8'h80;
    end
    m_vol = 0; m_ptr = 0; m_aok = 0; m_s08 = 0; m_seen = 0; m_lock = 0; m_pend = 0;
    m_wr = m_nv[0];
  endtask

  task automatic m_byte(input bit isa, input bit [7:0] d, output bit ea);
    bit ok;
    ea = 0; m_pend = 0;
    if (isa) begin
      ea = (d <= 8 && d != 7);
      m_aok = ea;
      if (ea) begin m_ptr = d[3:0]; m_s08 = (d == 8); m_seen = 0; m_lock = 0; end
    end else begin
      ok = m_aok && !m_lock && (!m_seen || m_s08);
      if (!ok) m_lock = 1;
      else begin
        m_seen = 1;
        if (m_ptr == 8) begin m_vol = d[7]; ea = (d[6:0] == 0); end
        else if (m_ptr == 1) ea = 1;
        else if (m_ptr == 0 && m_vol) begin m_wr = d; ea = 1; end
        else if (m_ptr <= 6) begin
          m_lock = 1;
          if (wp_n) begin
            ea = 1; m_pend = 1; m_pa = m_ptr; m_pd = d;
            if (m_ptr == 0) m_wr = d;
          end
        end
        m_ptr = nxt(m_ptr);
      end
    end
  endtask

  task automatic send_byte(input bit isa, input bit [7:0] d, input string req);
    bit ea;
    in_valid = 1; in_addr = isa; in_data = d;
    while (!in_ready) tick();
    tick();
    in_valid = 0;
    m_byte(isa, d, ea);
    chk(ack_valid == 1 && ack == ea, req, {ack_valid, ack}, {1'b1, ea});
    chk(tap_sel == m_wr, "R9", tap_sel, m_wr);
  endtask

  task automatic do_start();
    bus_start = 1; tick(); bus_start = 0;
    m_pend = 0; m_aok = 0; m_lock = 0;
  endtask

  task automatic do_stop(input string req);
    bit c;
    c = m_pend && wp_n;
    if (c) m_nv[m_pa] = m_pd;
    m_pend = 0; m_aok = 0; m_lock = 0;
    bus_stop = 1; tick(); bus_stop = 0;
    if (c) begin
      int hi = 0;
      while (busy && hi < 4*NVC) begin hi++; tick(); end
      chk(hi == NVC, "R12", hi, NVC);
    end else begin
      chk(busy == 0, req, busy, 0);
    end
  endtask

  task automatic do_read(input string req);
    bit [7:0] e;
    e = exp_rd(m_ptr);
    rd_req = 1; tick(); rd_req = 0;
    m_pend = 0; m_ptr = nxt(m_ptr);
    chk(rd_valid == 1 && rd_data == e, req, {rd_valid, rd_data}, {1'b1, e});
  endtask

  task automatic read_at(input bit [7:0] a, input int n, input string req);
    do_start(); send_byte(1, a, req); do_start();
    for (int i = 0; i < n; i++) do_read(req);
    do_stop(req);
  endtask

  task automatic write1(input bit [7:0] a, input bit [7:0] d, input string req);
    do_start(); send_byte(1, a, req); send_byte(0, d, req); do_stop(req);
  endtask

  initial begin
    void'($urandom(32'd7));
    model_reset(1);
    tick(); tick();
    // R1 reset state
    chk(tap_sel == 8'h80 && boot_done == 0, "R1", tap_sel, 8'h80);
    chk(in_ready == 0, "R1", in_ready, 0);
    nv_rst_n = 1; rst_n = 1;
    tick();
    chk(boot_done == 1 && tap_sel == 8'h80, "R1", {boot_done, tap_sel}, {1'b1, 8'h80});
    // R6 defaults and R7 sequential through reserved slot and wrap
    read_at(8'h05, 5, "R7");
    // R5 identity
    read_at(8'h01, 1, "R5");
    write1(8'h01, 8'h55, "R5");
    read_at(8'h01, 1, "R5");
    // R3 control register
    write1(8'h08, 8'h80, "R3");
    write1(8'h08, 8'h81, "R3");
    read_at(8'h08, 1, "R3");
    // R4 volatile bank: wiper only, no busy
    write1(8'h00, 8'h11, "R4");
    read_at(8'h00, 1, "R4");
    write1(8'h08, 8'h00, "R3");
    read_at(8'h00, 1, "R4");
    // R9 and R12: stored write to 00h, wiper moves at once, busy blocks reads
    do_start(); send_byte(1, 8'h00, "R4"); send_byte(0, 8'h3C, "R9");
    bus_stop = 1; tick(); bus_stop = 0;
    m_nv[0] = 8'h3C; m_pend = 0; m_aok = 0;
    chk(busy == 1 && in_ready == 0, "R12", {busy, in_ready}, 2'b10);
    rd_req = 1; tick(); rd_req = 0;
    chk(rd_valid == 0, "R12", rd_valid, 0);
    wp_n = 0;   // R11 low during cycle: no effect
    while (busy) tick();
    wp_n = 1;
    read_at(8'h00, 1, "R11");
    // R8 no stop: restart discards
    do_start(); send_byte(1, 8'h03, "R8"); send_byte(0, 8'hAA, "R8"); do_start(); do_stop("R8");
    read_at(8'h03, 1, "R8");
    // R11 protected data byte and protect at stop
    wp_n = 0; write1(8'h04, 8'h77, "R11"); wp_n = 1;
    do_start(); send_byte(1, 8'h04, "R11"); send_byte(0, 8'h66, "R11");
    wp_n = 0; do_stop("R11"); wp_n = 1;
    read_at(8'h04, 1, "R11");
    // R10 multi-byte from control register
    do_start(); send_byte(1, 8'h08, "R10"); send_byte(0, 8'h00, "R10");
    send_byte(0, 8'h5A, "R10"); send_byte(0, 8'h12, "R10"); do_stop("R10");
    read_at(8'h00, 1, "R10");
    do_start(); send_byte(1, 8'h08, "R10"); send_byte(0, 8'h80, "R10");
    send_byte(0, 8'h22, "R10"); send_byte(0, 8'h33, "R10"); do_stop("R10");
    do_start(); send_byte(1, 8'h02, "R10"); send_byte(0, 8'h01, "R10");
    send_byte(0, 8'h02, "R10"); do_stop("R10");
    read_at(8'h02, 2, "R10");
    // R2 illegal pointers
    do_start(); send_byte(1, 8'h07, "R2"); send_byte(0, 8'h44, "R2"); do_stop("R2");
    do_start(); send_byte(1, 8'h09, "R2"); send_byte(0, 8'h44, "R2"); do_stop("R2");
    do_start(); send_byte(1, 8'hF3, "R2"); send_byte(0, 8'h44, "R2"); do_stop("R2");
    // R1 second reset keeps stored value 3Ch
    write1(8'h08, 8'h00, "R3");
    write1(8'h00, 8'h3C, "R6");
    rst_n = 0; tick();
    chk(tap_sel == 8'h80, "R1", tap_sel, 8'h80);
    rst_n = 1; model_reset(0); tick();
    chk(tap_sel == 8'h3C && boot_done, "R1", tap_sel, 8'h3C);
    // random transfers
    for (int it = 0; it < 300; it++) begin
      int kind = $urandom % 3;
      bit [7:0] a = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 10);
      if (kind == 0) begin
        read_at(a, 1 + $urandom % 4, "R7");
      end else begin
        int nb = 1 + $urandom % 3;
        do_start(); send_byte(1, a, "R2");
        for (int b = 0; b < nb; b++) begin
          bit [7:0] d = ($urandom % 3 == 0) ? 8'($urandom) : {1'($urandom), 7'd0};
          wp_n = ($urandom % 5 != 0);
          send_byte(0, d, "R10");
        end
        wp_n = ($urandom % 6 != 0);
        if ($urandom % 5 == 0) do_start();
        do_stop("R8");
        wp_n = 1;
      end
    end
    summary();
  end
endmodule